// File: doc/BRIEF.md
# Fully Associative LRU Tag Store with Stack-Distance Profiling

This block is the tag side of a single-set cache of ENTRIES slots. Each slot keeps a block address and a valid bit. A per-slot age counter keeps all slots in one total recency order, from the most recent slot (age 0) to the least recent slot (age ENTRIES-1). One request arrives per cycle and carries an operation code and a byte address. The block answers, one cycle later, with hit or miss, the slot involved, the byte offset within the block, and the victim block address when an allocation evicts a valid block.

A single recency order contains every smaller LRU cache of power-of-two size. Because of this, each response also carries a residency mask that tells which smaller caches would have held the block. Bit k stands for a cache of 2^k slots. The block keeps a hit counter and a miss counter for each of these sizes, plus a total access counter. An address trace can therefore be profiled for several cache sizes in one pass. A constant output gives the configured hit latency to the surrounding pipeline.

Top module: `lru_tagstore`

## Requirements
- R1: The stored tag is the address with its low log2(BLOCK_BYTES) bits dropped. Two addresses in the same block match the same slot. The response reports the dropped bits as the byte offset.
- R2: After reset every slot is invalid, every counter is zero, and the recency order is slot 0 as most recent through slot ENTRIES-1 as least recent.
- R3: A lookup (op 0) or an allocate (op 3) that hits reports the matching slot and moves it to the most recent position. Every slot that was more recent moves down by one place.
- R4: A probe (op 1) reports hit, slot and residency mask, and leaves the recency order unchanged.
- R5: A lookup that misses changes nothing: the block is not inserted and the order is unchanged.
- R6: An allocate that misses writes the block into the least recent slot and makes that slot the most recent. It reports that slot. It raises the victim flag, with the old block address, only when the replaced slot was valid.
- R7: An invalidate (op 2) that hits clears the slot's valid bit and makes it the least recent slot, so it is the next victim. Invalid slots are therefore always used before any valid slot.
- R8: Residency mask bit k (k = 0 .. log2(ENTRIES)-1) is set exactly when the request hits a slot whose recency depth, taken before the update, is below 2^k.
- R9: Only lookups and allocates count. Each one adds one to the access counter. For each size k it adds one to hit counter k if mask bit k is set, and to miss counter k otherwise. Probes and invalidates leave all counters unchanged.
- R10: The request is always accepted. A response is valid exactly one cycle after each accepted request, and at no other time.
- R11: hit_latency always equals the HIT_LAT parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always high; a request is taken every cycle |
| req_op | input | 2 | 0 lookup, 1 probe, 2 invalidate, 3 allocate |
| req_addr | input | ADDR_W | Byte address |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | The block was resident |
| rsp_index | output | log2(ENTRIES) | Slot that hit or was filled |
| rsp_offset | output | log2(BLOCK_BYTES) | Byte offset inside the block |
| rsp_mask | output | log2(ENTRIES) | Residency mask per smaller size |
| rsp_victim_valid | output | 1 | A valid block was evicted |
| rsp_victim_addr | output | ADDR_W | Block address of the evicted block |
| hit_latency | output | 8 | Constant hit latency |
| hit_cnt | output | log2(ENTRIES)*CNT_W | Hit counters, size k in slice k |
| miss_cnt | output | log2(ENTRIES)*CNT_W | Miss counters, size k in slice k |
| access_cnt | output | CNT_W | Counted accesses |

## Verification
A wrong age value, such as a duplicated age, does not cause an immediate miss. It shows first in the residency mask of the next access to that block, which reports the wrong depth. It shows next in the choice of victim, and that can be many allocations later. For this reason the bench keeps an independent recency list and compares every response field on every cycle, so a broken order is seen on the first access whose depth moves. A slot that stays valid by mistake after an invalidate shows on the next probe, which hits when it should miss. The counters collect the mask errors, and the bench checks them at the end of the trace.

// File: rtl/lru_tag_pkg.sv
package lru_tag_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_PROBE  = 2'd1,
    OP_INVAL  = 2'd2,
    OP_ALLOC  = 2'd3
  } lru_op_e;
endpackage

// File: rtl/lru_match.sv
// Parallel tag compare over all slots, with one-hot to index encoding.
module lru_match #(
  parameter int N     = 16,
  parameter int TAG_W = 26,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [TAG_W-1:0] tags  [N],
  input  logic [N-1:0]     valid,
  input  logic [TAG_W-1:0] key,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);
  logic [N-1:0] match;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = valid[i] && (tags[i] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/lru_age.sv
// Per-slot age registers that hold a permutation of 0..N-1.
module lru_age #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             promote_en,
  input  logic [IDX_W-1:0] promote_idx,
  input  logic             demote_en,
  input  logic [IDX_W-1:0] demote_idx,
  output logic [IDX_W-1:0] ages [N],
  output logic [IDX_W-1:0] victim_idx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

  logic [IDX_W-1:0] age_q [N];
  logic [IDX_W-1:0] prom_old, dem_old;

  assign prom_old = age_q[promote_idx];
  assign dem_old  = age_q[demote_idx];

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        age_q[i] <= IDX_W'(i);
      end else if (promote_en) begin
        if (promote_idx == IDX_W'(i))   age_q[i] <= '0;
        else if (age_q[i] < prom_old)   age_q[i] <= age_q[i] + 1'b1;
      end else if (demote_en) begin
        if (demote_idx == IDX_W'(i))    age_q[i] <= OLDEST;
        else if (age_q[i] > dem_old)    age_q[i] <= age_q[i] - 1'b1;
      end
    end
    assign ages[i] = age_q[i];
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == OLDEST) victim_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/lru_tagstore.sv
module lru_tagstore #(
  parameter int ENTRIES     = 16,
  parameter int BLOCK_BYTES = 64,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int HIT_LAT     = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int OFF_W  = $clog2(BLOCK_BYTES),
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int NSIZES = IDX_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_op,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic [IDX_W-1:0]        rsp_index,
  output logic [OFF_W-1:0]        rsp_offset,
  output logic [NSIZES-1:0]       rsp_mask,
  output logic                    rsp_victim_valid,
  output logic [ADDR_W-1:0]       rsp_victim_addr,
  output logic [7:0]              hit_latency,
  output logic [NSIZES*CNT_W-1:0] hit_cnt,
  output logic [NSIZES*CNT_W-1:0] miss_cnt,
  output logic [CNT_W-1:0]        access_cnt
);
  import lru_tag_pkg::*;

  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [IDX_W-1:0]   ages [ENTRIES];
  logic [IDX_W-1:0]   victim_idx, hit_idx, hit_age, promote_idx;
  logic               hit, promote_en, demote_en, fill, counted;
  logic [NSIZES-1:0]  mask;
  lru_op_e            op;
  logic [TAG_W-1:0]   key;

  assign op          = lru_op_e'(req_op);
  assign key         = req_addr[ADDR_W-1:OFF_W];
  assign req_ready   = 1'b1;
  assign hit_latency = 8'(HIT_LAT);

  lru_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_match (
    .tags(tag_q), .valid(valid_q), .key(key), .hit(hit), .hit_idx(hit_idx)
  );

  assign hit_age     = ages[hit_idx];
  assign fill        = req_valid && (op == OP_ALLOC) && !hit;
  assign promote_en  = (req_valid && hit && (op == OP_LOOKUP || op == OP_ALLOC)) || fill;
  assign promote_idx = hit ? hit_idx : victim_idx;
  assign demote_en   = req_valid && (op == OP_INVAL) && hit;
  assign counted     = req_valid && (op == OP_LOOKUP || op == OP_ALLOC);

  lru_age #(.N(ENTRIES)) u_age (
    .clk(clk), .rst(rst),
    .promote_en(promote_en), .promote_idx(promote_idx),
    .demote_en(demote_en), .demote_idx(hit_idx),
    .ages(ages), .victim_idx(victim_idx)
  );

  // Tag and valid storage
  always_ff @(posedge clk) begin
    if (fill) tag_q[victim_idx] <= key;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (fill) valid_q[victim_idx] <= 1'b1;
    else if (demote_en) valid_q[hit_idx] <= 1'b0;
  end

  // Residency mask and per-size statistics
  for (genvar k = 0; k < NSIZES; k++) begin : g_size
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(1 << k);
    logic [CNT_W-1:0] hits_q, misses_q;
    assign mask[k] = hit && (hit_age < LIMIT);
    always_ff @(posedge clk) begin
      if (rst) begin
        hits_q   <= '0;
        misses_q <= '0;
      end else if (counted) begin
        if (mask[k]) hits_q   <= hits_q + 1'b1;
        else         misses_q <= misses_q + 1'b1;
      end
    end
    assign hit_cnt[k*CNT_W +: CNT_W]  = hits_q;
    assign miss_cnt[k*CNT_W +: CNT_W] = misses_q;
  end

  always_ff @(posedge clk) begin
    if (rst) access_cnt <= '0;
    else if (counted) access_cnt <= access_cnt + 1'b1;
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid        <= 1'b0;
      rsp_hit          <= 1'b0;
      rsp_index        <= '0;
      rsp_offset       <= '0;
      rsp_mask         <= '0;
      rsp_victim_valid <= 1'b0;
      rsp_victim_addr  <= '0;
    end else begin
      rsp_valid        <= req_valid;
      rsp_hit          <= req_valid && hit;
      rsp_index        <= hit ? hit_idx : (fill ? victim_idx : '0);
      rsp_offset       <= req_addr[OFF_W-1:0];
      rsp_mask         <= req_valid ? mask : '0;
      rsp_victim_valid <= fill && valid_q[victim_idx];
      rsp_victim_addr  <= {tag_q[victim_idx], {OFF_W{1'b0}}};
    end
  end
endmodule

// File: rtl/lru_tagstore_chk.sv
module lru_tagstore_chk #(
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 16,
  localparam int NSIZES = $clog2(ENTRIES)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [NSIZES-1:0] rsp_mask,
  input logic              rsp_victim_valid,
  input logic [CNT_W-1:0]  access_cnt
);
  a_r10_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r10_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r8_mask_needs_hit: assert property (@(posedge clk) disable iff (rst)
    (rsp_mask != '0) |-> rsp_hit);
  a_r8_mask_nested: assert property (@(posedge clk) disable iff (rst)
    (NSIZES'(rsp_mask << 1) & ~rsp_mask) == '0);
  a_r6_victim_on_miss: assert property (@(posedge clk) disable iff (rst)
    rsp_victim_valid |-> !rsp_hit);
  a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == 2'd0 || req_op == 2'd3)) |=> access_cnt == $past(access_cnt) + 1'b1);
  a_r9_probe_uncounted: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == 2'd1 || req_op == 2'd2)) |=> $stable(access_cnt));
endmodule

bind lru_tagstore lru_tagstore_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_mask(rsp_mask),
  .rsp_victim_valid(rsp_victim_valid), .access_cnt(access_cnt)
);

// File: tb/lru_tagstore_test.sv
module lru_tagstore_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16, BB = 64, AW = 32, CW = 16, HL = 2;
  localparam int IW = 4, OW = 6, NS = 4;

  logic clk = 1'b0, rst = 1'b1, req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_victim_valid;
  logic [IW-1:0] rsp_index;
  logic [OW-1:0] rsp_offset;
  logic [NS-1:0] rsp_mask;
  logic [AW-1:0] rsp_victim_addr;
  logic [7:0] hit_latency;
  logic [NS*CW-1:0] hit_cnt, miss_cnt;
  logic [CW-1:0] access_cnt;

  lru_tagstore #(.ENTRIES(N), .BLOCK_BYTES(BB), .ADDR_W(AW), .CNT_W(CW), .HIT_LAT(HL)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_index(rsp_index), .rsp_offset(rsp_offset), .rsp_mask(rsp_mask),
    .rsp_victim_valid(rsp_victim_valid), .rsp_victim_addr(rsp_victim_addr),
    .hit_latency(hit_latency), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt),
    .access_cnt(access_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic hit; int idx; logic chk_idx; int off; logic [NS-1:0] mask;
    logic vv; logic [AW-1:0] va; string rq;
  } exp_t;

  exp_t sb[$];
  int checks = 0, failures = 0;
  bit done = 0;

  // reference model: recency list of slot ids, most recent first
  int order[$];
  bit mvalid[N];
  int mtag[N];
  int m_acc = 0;
  int m_hit[NS], m_miss[NS];

  task automatic check(input bit ok, input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic send(input int op, input int addr, input string rq);
    exp_t e;
    int tag, pos, s;
    tag = addr >> OW;
    pos = -1;
    foreach (order[i]) if (pos < 0 && mvalid[order[i]] && mtag[order[i]] == tag) pos = i;
    e.rq = rq; e.hit = (pos >= 0); e.off = addr % BB; e.vv = 0; e.va = '0;
    e.idx = 0; e.chk_idx = e.hit;
    for (int k = 0; k < NS; k++) e.mask[k] = e.hit && (pos < (1 << k));
    if (e.hit) e.idx = order[pos];
    if (op == 0 || op == 3) begin
      m_acc++;
      for (int k = 0; k < NS; k++) if (e.mask[k]) m_hit[k]++; else m_miss[k]++;
    end
    if ((op == 0 || op == 3) && e.hit) begin
      s = order[pos]; order.delete(pos); order.push_front(s);
    end else if (op == 3) begin
      s = order[N-1];
      e.vv = mvalid[s]; e.va = AW'(mtag[s] << OW); e.idx = s; e.chk_idx = 1;
      mtag[s] = tag; mvalid[s] = 1;
      order.delete(N-1); order.push_front(s);
    end else if (op == 2 && e.hit) begin
      s = order[pos]; mvalid[s] = 0; order.delete(pos); order.push_back(s);
    end
    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_addr = AW'(addr);
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
  endtask

  // monitor: compares each response against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        if (sb.size() == 0) check(0, "R10", "unexpected response", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(rsp_hit == e.hit, e.rq, "hit", rsp_hit, e.hit);
          if (e.chk_idx) check(rsp_index == IW'(e.idx), e.rq, "index", rsp_index, e.idx);
          check(rsp_offset == OW'(e.off), "R1", "offset", rsp_offset, e.off);
          check(rsp_mask == e.mask, "R8", "mask", rsp_mask, e.mask);
          check(rsp_victim_valid == e.vv, e.rq, "victim_valid", rsp_victim_valid, e.vv);
          if (e.vv) check(rsp_victim_addr == e.va, e.rq, "victim_addr", rsp_victim_addr, e.va);
        end
      end
    end
  end

  function automatic int blk(input int n, input int off);
    return n * BB + off;
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin order.push_back(i); mvalid[i] = 0; mtag[i] = 0; end
    for (int k = 0; k < NS; k++) begin m_hit[k] = 0; m_miss[k] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(rsp_valid == 0, "R2", "rsp_valid after reset", rsp_valid, 0);
    check(access_cnt == 0 && hit_cnt == '0 && miss_cnt == '0, "R2", "counters after reset", access_cnt, 0);
    check(req_ready == 1, "R10", "req_ready", req_ready, 1);
    check(hit_latency == 8'(HL), "R11", "hit_latency", hit_latency, HL);

    send(1, blk(7, 3), "R2");              // empty store: probe misses
    send(0, blk(7, 5), "R5");              // lookup miss, no insert
    send(1, blk(7, 0), "R5");              // still absent
    for (int i = 0; i < N; i++) send(3, blk(100 + i, i), "R6");  // fill invalid slots
    send(0, blk(100, 33), "R1");           // same block, other offset, deepest
    send(0, blk(100, 1), "R3");            // now most recent
    send(1, blk(110, 0), "R4");
    send(1, blk(110, 9), "R4");            // same depth again
    send(0, blk(108, 2), "R3");
    send(1, blk(109, 0), "R3");            // shifted down by one
    idle();
    @(negedge clk);
    check(rsp_valid == 0, "R10", "no response when idle", rsp_valid, 0);
    send(3, blk(200, 4), "R6");            // evicts valid LRU block
    send(3, blk(108, 0), "R3");            // allocate that hits
    send(2, blk(105, 0), "R7");            // invalidate
    send(1, blk(105, 0), "R7");            // gone
    send(3, blk(201, 0), "R7");            // reuses invalidated slot
    send(2, blk(999, 0), "R7");            // invalidate miss
    for (int i = 0; i < 40; i++) send((i % 3 == 2) ? 1 : 0, blk(100 + (i * 7) % 22, i), "R8");
    for (int i = 0; i < 20; i++) send(3, blk(300 + (i * 5) % 24, 0), "R6");
    idle();
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R10", "responses outstanding", sb.size(), 0);
    check(access_cnt == CW'(m_acc), "R9", "access_cnt", access_cnt, m_acc);
    for (int k = 0; k < NS; k++) begin
      check(hit_cnt[k*CW +: CW] == CW'(m_hit[k]), "R9", $sformatf("hit_cnt[%0d]", k), hit_cnt[k*CW +: CW], m_hit[k]);
      check(miss_cnt[k*CW +: CW] == CW'(m_miss[k]), "R9", $sformatf("miss_cnt[%0d]", k), miss_cnt[k*CW +: CW], m_miss[k]);
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL R10 watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule